// File: doc/BRIEF.md
# Indirect Sub-Addressed Host Register Bank

This block is the register front end that a host processor sees on a token-passing network controller. The host uses a small synchronous bus with a 3-bit address, an 8-bit write bus, a registered 8-bit read bus, a write strobe and a read strobe. One host address is a data window. A 3-bit pointer selects which of eight internal registers the window reaches: tentative ID, node ID, first setup, next ID, second setup, bus control, DMA count and one reserved slot. The host can load the whole pointer through a pointer register. The low two pointer bits are also the low two bits of the configuration register.

The configuration register holds a software reset bit, a command-chaining enable and a transmit enable. It also holds three general bits and the two shared pointer bits. Any configuration write clears the top pointer bit. While the software reset bit is 1, the block keeps the status, diagnostic and next-ID registers at zero. Every other register keeps its value. The block drives the reset level and both enables out to the network logic.

Host address map: 0 status, 1 diagnostic status, 2 pointer register, 6 configuration, 7 data window. Addresses 3, 4 and 5 read as zero and ignore writes.

Top module: `sarb_top`

## Requirements
- R1: With pointer value n, for n from 0 to 6, a write to host address 7 stores into internal register n, and a read of address 7 returns that value. The slots are 0 tentative ID, 1 node ID, 2 setup 1, 3 next ID, 4 setup 2, 5 bus control and 6 DMA count.
- R2: A write to host address 2 loads pointer bits 2..0 from write-data bits 2..0. A read of address 2 returns the pointer in bits 2..0 and zeros in bits 7..3.
- R3: Pointer bits 1..0 and configuration bits 1..0 are one storage. A configuration write sets pointer bits 1..0. A pointer write changes configuration bits 1..0 as read at address 6.
- R4: Every write to the configuration register (address 6) clears pointer bit 2, whatever value is written.
- R5: While configuration bit 7 is 1, output soft_rst_o is 1 and status, diagnostic status and next ID (pointer 3) are held at zero. Writes to them have no effect. The configuration register and the other internal registers keep their values. Clearing bit 7 releases soft_rst_o on the next cycle.
- R6: Output tx_en_o follows configuration bit 5, and chain_en_o follows configuration bit 6. Each changes only on a configuration write.
- R7: Pointer value 7 is reserved. Writes through the data window to it do not change any register, and reads of it return 0.
- R8: Hardware reset (rst high at a clock edge) clears every register, including configuration and all pointer bits. All outputs read 0 afterwards.
- R9: rdata shows the selected value one cycle after a read strobe, and then holds until the next read strobe. A write in the same cycle as the strobe is not yet visible. Addresses 3, 4 and 5 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| addr | input | 3 | Host register address |
| wdata | input | 8 | Host write data |
| wr | input | 1 | Write strobe |
| rd | input | 1 | Read strobe |
| rdata | output | 8 | Registered read data |
| soft_rst_o | output | 1 | Held software reset level (configuration bit 7) |
| tx_en_o | output | 1 | Transmit enable (configuration bit 5) |
| chain_en_o | output | 1 | Command-chaining enable (configuration bit 6) |

## Verification
The bench first loads pointer 4..6, then writes the configuration register. If the design does not clear pointer bit 2, the data window lands on the wrong register. Soft reset is tested on both sides: the cleared registers must read zero even after a write while reset is held, and the node ID, setup and configuration values must survive. A design that clears too much, or that lets writes through during soft reset, shows the wrong values. The bench also covers the reserved slot, the alias seen from both addresses, and a read strobe in the same cycle as a write. A design that reads combinationally or ignores the alias returns the new value where the old one is expected.

// File: rtl/sarb_pkg.sv
package sarb_pkg;
    localparam int DW    = 8;
    localparam int AW    = 3;
    localparam int PTRW  = 3;
    localparam int NSLOT = 1 << PTRW;
    localparam int NSOFT = 2;

    localparam logic [AW-1:0] HA_STATUS = 3'd0;
    localparam logic [AW-1:0] HA_DIAG   = 3'd1;
    localparam logic [AW-1:0] HA_PTR    = 3'd2;
    localparam logic [AW-1:0] HA_CFG    = 3'd6;
    localparam logic [AW-1:0] HA_DATA   = 3'd7;

    typedef enum logic [PTRW-1:0] {
        SL_TENT   = 3'd0,
        SL_NODE   = 3'd1,
        SL_SETUP1 = 3'd2,
        SL_NEXT   = 3'd3,
        SL_SETUP2 = 3'd4,
        SL_BUSCTL = 3'd5,
        SL_DMA    = 3'd6,
        SL_RSVD   = 3'd7
    } slot_e;

    typedef struct packed {
        logic       srst;
        logic       chain;
        logic       txen;
        logic [2:0] spare;
        logic [1:0] ptr_lo;
    } cfg_t;

    function automatic logic [NSLOT-1:0] slot_soft_mask();
        logic [NSLOT-1:0] m;
        m = '0;
        m[SL_NEXT] = 1'b1;
        return m;
    endfunction

    function automatic logic [DW-1:0] pad_ptr(input logic [PTRW-1:0] p);
        return {{(DW-PTRW){1'b0}}, p};
    endfunction
endpackage

// File: rtl/sarb_ctrl.sv
module sarb_ctrl
    import sarb_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            cfg_we,
    input  logic            ptr_we,
    input  logic [DW-1:0]   wdata,
    output cfg_t            cfg,
    output logic [PTRW-1:0] ptr
);
    logic ptr_hi;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg    <= '0;
            ptr_hi <= 1'b0;
        end else if (cfg_we) begin
            cfg    <= cfg_t'(wdata);
            ptr_hi <= 1'b0;
        end else if (ptr_we) begin
            cfg.ptr_lo <= wdata[1:0];
            ptr_hi     <= wdata[2];
        end
    end

    assign ptr = {ptr_hi, cfg.ptr_lo};

    // R4: configuration write clears the top pointer bit
    assert_ptrhi_clear_R4: assert property (@(posedge clk) disable iff (rst)
        cfg_we |=> (ptr[2] == 1'b0));

    // R3: pointer write is visible in configuration low bits
    assert_alias_R3: assert property (@(posedge clk) disable iff (rst)
        (ptr_we && !cfg_we) |=> (cfg.ptr_lo == $past(wdata[1:0])));

    // R6: enables move only on configuration writes
    assert_enables_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !cfg_we |=> ($stable(cfg.txen) && $stable(cfg.chain)));
endmodule

// File: rtl/sarb_bank.sv
module sarb_bank #(
    parameter int              NREG      = 8,
    parameter int              DW        = 8,
    parameter int              SELW      = (NREG > 1) ? $clog2(NREG) : 1,
    parameter logic [NREG-1:0] SOFT_MASK = '0,
    parameter int              RSVD_IDX  = -1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               soft_rst,
    input  logic               we,
    input  logic [SELW-1:0]    sel,
    input  logic [DW-1:0]      wdata,
    output logic [NREG*DW-1:0] q_flat
);
    for (genvar i = 0; i < NREG; i++) begin : g_slot
        if (i == RSVD_IDX) begin : g_rsvd
            assign q_flat[i*DW +: DW] = '0;
        end else begin : g_store
            logic [DW-1:0] r;
            always_ff @(posedge clk) begin
                if (rst)
                    r <= '0;
                else if (SOFT_MASK[i] && soft_rst)
                    r <= '0;
                else if (we && (sel == SELW'(i)))
                    r <= wdata;
            end
            assign q_flat[i*DW +: DW] = r;

            if (SOFT_MASK[i]) begin : g_chk
                // R5: held soft reset forces this register to zero
                assert_softclr_R5: assert property (@(posedge clk) disable iff (rst)
                    soft_rst |=> (q_flat[i*DW +: DW] == '0));
            end
        end
    end

    if (RSVD_IDX >= 0) begin : g_rsvd_chk
        // R7: write to the reserved slot leaves the bank unchanged
        assert_rsvd_ignored_R7: assert property (@(posedge clk) disable iff (rst)
            (we && (sel == SELW'(RSVD_IDX)) && !soft_rst) |=> $stable(q_flat));
    end
endmodule

// File: rtl/sarb_rdport.sv
module sarb_rdport
    import sarb_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                rd,
    input  logic [AW-1:0]       addr,
    input  cfg_t                cfg,
    input  logic [PTRW-1:0]     ptr,
    input  logic [NSLOT*DW-1:0] slot_flat,
    input  logic [NSOFT*DW-1:0] soft_flat,
    output logic [DW-1:0]       rdata
);
    logic [DW-1:0] rmux;

    always_comb begin
        case (addr)
            HA_STATUS: rmux = soft_flat[0 +: DW];
            HA_DIAG:   rmux = soft_flat[DW +: DW];
            HA_PTR:    rmux = pad_ptr(ptr);
            HA_CFG:    rmux = DW'(cfg);
            HA_DATA:   rmux = slot_flat[32'(ptr)*DW +: DW];
            default:   rmux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            rdata <= '0;
        else if (rd)
            rdata <= rmux;
    end

    // R9: read data holds between strobes
    assert_rdata_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !rd |=> $stable(rdata));
endmodule

// File: rtl/sarb_top.sv
module sarb_top
    import sarb_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic          wr,
    input  logic          rd,
    output logic [DW-1:0] rdata,
    output logic          soft_rst_o,
    output logic          tx_en_o,
    output logic          chain_en_o
);
    cfg_t                cfg;
    logic [PTRW-1:0]     ptr;
    logic [NSLOT*DW-1:0] slot_flat;
    logic [NSOFT*DW-1:0] soft_flat;
    logic                cfg_we, ptr_we, slot_we, soft_we;
    logic                soft_sel;

    assign cfg_we   = wr && (addr == HA_CFG);
    assign ptr_we   = wr && (addr == HA_PTR);
    assign slot_we  = wr && (addr == HA_DATA);
    assign soft_we  = wr && ((addr == HA_STATUS) || (addr == HA_DIAG));
    assign soft_sel = (addr == HA_DIAG);

    sarb_ctrl u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .cfg_we (cfg_we),
        .ptr_we (ptr_we),
        .wdata  (wdata),
        .cfg    (cfg),
        .ptr    (ptr)
    );

    sarb_bank #(
        .NREG      (NSLOT),
        .DW        (DW),
        .SOFT_MASK (slot_soft_mask()),
        .RSVD_IDX  (int'(SL_RSVD))
    ) u_slots (
        .clk      (clk),
        .rst      (rst),
        .soft_rst (cfg.srst),
        .we       (slot_we),
        .sel      (ptr),
        .wdata    (wdata),
        .q_flat   (slot_flat)
    );

    sarb_bank #(
        .NREG      (NSOFT),
        .DW        (DW),
        .SOFT_MASK ({NSOFT{1'b1}}),
        .RSVD_IDX  (-1)
    ) u_soft (
        .clk      (clk),
        .rst      (rst),
        .soft_rst (cfg.srst),
        .we       (soft_we),
        .sel      (soft_sel),
        .wdata    (wdata),
        .q_flat   (soft_flat)
    );

    sarb_rdport u_rd (
        .clk       (clk),
        .rst       (rst),
        .rd        (rd),
        .addr      (addr),
        .cfg       (cfg),
        .ptr       (ptr),
        .slot_flat (slot_flat),
        .soft_flat (soft_flat),
        .rdata     (rdata)
    );

    assign soft_rst_o = cfg.srst;
    assign tx_en_o    = cfg.txen;
    assign chain_en_o = cfg.chain;
endmodule

// File: tb/tb_sarb_top.sv
module tb_sarb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0;
    logic       wr = 1'b0;
    logic       rd = 1'b0;
    logic [7:0] rdata;
    logic       soft_rst_o, tx_en_o, chain_en_o;

    int total = 0;
    int fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    sarb_top dut (
        .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .wr(wr), .rd(rd),
        .rdata(rdata), .soft_rst_o(soft_rst_o), .tx_en_o(tx_en_o),
        .chain_en_o(chain_en_o)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
        d = rdata;
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    task automatic hw_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset_state();
        logic [7:0] v;
        check("R8 rdata after reset", rdata, 8'h00);
        check("R8 outputs after reset", {5'b0, soft_rst_o, tx_en_o, chain_en_o}, 8'h00);
        rd_reg(3'd6, v); check("R8 config after reset", v, 8'h00);
        rd_reg(3'd2, v); check("R8 pointer after reset", v, 8'h00);
    endtask

    task automatic t_indirect();
        logic [7:0] v;
        for (int n = 0; n < 7; n++) begin
            wr_reg(3'd2, 8'(n));
            wr_reg(3'd7, 8'h30 + 8'(n));
        end
        for (int n = 6; n >= 0; n--) begin
            wr_reg(3'd2, 8'(n));
            rd_reg(3'd7, v);
            check($sformatf("R1 slot %0d", n), v, 8'h30 + 8'(n));
        end
    endtask

    task automatic t_ptr_reg();
        logic [7:0] v;
        wr_reg(3'd2, 8'hFD);
        rd_reg(3'd2, v); check("R2 pointer reads 101 with zero upper bits", v, 8'h05);
        rd_reg(3'd7, v); check("R2 pointer 5 selects bus control", v, 8'h35);
    endtask

    task automatic t_alias();
        logic [7:0] v;
        wr_reg(3'd6, 8'h1E);
        rd_reg(3'd2, v); check("R3 config low bits seen in pointer", v, 8'h02);
        wr_reg(3'd2, 8'h01);
        rd_reg(3'd6, v); check("R3 pointer write seen in config", v, 8'h1D);
        rd_reg(3'd7, v); check("R3 window at node id", v, 8'h31);
    endtask

    task automatic t_ptrhi_clear();
        logic [7:0] v;
        wr_reg(3'd2, 8'h06);
        wr_reg(3'd6, 8'h03);
        rd_reg(3'd2, v); check("R4 config write clears pointer bit 2", v, 8'h03);
        rd_reg(3'd7, v); check("R4 window reaches next id not reserved", v, 8'h33);
        wr_reg(3'd6, 8'h00);
    endtask

    task automatic t_enables();
        wr_reg(3'd6, 8'h20);
        check("R6 tx enable set", {6'b0, tx_en_o, chain_en_o}, 8'h02);
        wr_reg(3'd6, 8'h40);
        check("R6 chain enable set, tx cleared", {6'b0, tx_en_o, chain_en_o}, 8'h01);
        wr_reg(3'd2, 8'h00);
        wr_reg(3'd7, 8'h30);
        check("R6 non-config writes leave enables", {6'b0, tx_en_o, chain_en_o}, 8'h01);
        wr_reg(3'd6, 8'h00);
    endtask

    task automatic t_softrst();
        logic [7:0] v;
        wr_reg(3'd0, 8'hA1);
        wr_reg(3'd1, 8'hA2);
        wr_reg(3'd6, 8'hA3);
        check("R5 soft reset level", {7'b0, soft_rst_o}, 8'h01);
        idle();
        rd_reg(3'd0, v); check("R5 status cleared", v, 8'h00);
        rd_reg(3'd1, v); check("R5 diag cleared", v, 8'h00);
        rd_reg(3'd7, v); check("R5 next id cleared", v, 8'h00);
        wr_reg(3'd7, 8'h77);
        wr_reg(3'd0, 8'h55);
        rd_reg(3'd7, v); check("R5 next id write ignored in reset", v, 8'h00);
        rd_reg(3'd0, v); check("R5 status write ignored in reset", v, 8'h00);
        rd_reg(3'd6, v); check("R5 config retained", v, 8'hA3);
        wr_reg(3'd2, 8'h02);
        rd_reg(3'd7, v); check("R5 setup 1 retained", v, 8'h32);
        wr_reg(3'd6, 8'h00);
        check("R5 soft reset released", {7'b0, soft_rst_o}, 8'h00);
        wr_reg(3'd0, 8'h5A);
        rd_reg(3'd0, v); check("R5 status writable after release", v, 8'h5A);
    endtask

    task automatic t_rsvd();
        logic [7:0] v;
        wr_reg(3'd2, 8'h07);
        wr_reg(3'd7, 8'hEE);
        rd_reg(3'd7, v); check("R7 reserved reads 0", v, 8'h00);
        for (int n = 0; n < 7; n++) begin
            if (n != 3) begin
                wr_reg(3'd2, 8'(n));
                rd_reg(3'd7, v);
                check($sformatf("R7 slot %0d untouched", n), v, 8'h30 + 8'(n));
            end
        end
    endtask

    task automatic t_rdtiming();
        logic [7:0] v;
        wr_reg(3'd2, 8'h04);
        @(negedge clk);
        addr = 3'd7; wdata = 8'h99; wr = 1'b1; rd = 1'b1;
        @(negedge clk);
        wr = 1'b0; rd = 1'b0;
        check("R9 same-cycle write not visible", rdata, 8'h34);
        wr_reg(3'd2, 8'h00);
        idle();
        check("R9 rdata holds without strobe", rdata, 8'h34);
        wr_reg(3'd2, 8'h04);
        rd_reg(3'd7, v); check("R9 written value on next read", v, 8'h99);
        for (int a = 3; a < 6; a++) begin
            wr_reg(3'(a), 8'hFF);
            rd_reg(3'(a), v);
            check($sformatf("R9 unmapped address %0d reads 0", a), v, 8'h00);
        end
    endtask

    task automatic t_hwreset();
        logic [7:0] v;
        wr_reg(3'd0, 8'h11);
        wr_reg(3'd6, 8'h61);
        wr_reg(3'd2, 8'h05);
        hw_reset();
        check("R8 outputs cleared", {5'b0, soft_rst_o, tx_en_o, chain_en_o}, 8'h00);
        rd_reg(3'd6, v); check("R8 config cleared", v, 8'h00);
        rd_reg(3'd2, v); check("R8 pointer cleared", v, 8'h00);
        rd_reg(3'd0, v); check("R8 status cleared", v, 8'h00);
        rd_reg(3'd7, v); check("R8 tentative id cleared", v, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset_state();
        t_indirect();
        t_ptr_reg();
        t_alias();
        t_ptrhi_clear();
        t_enables();
        t_softrst();
        t_rsvd();
        t_rdtiming();
        t_hwreset();
        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule